// File: doc/BRIEF.md
# Completion-Boundary Read Request Splitter

This block turns one large memory-read descriptor, a byte start address plus a length in dwords, into a train of smaller read requests. Each request is cut so that it never spans a read completion boundary. Because of that, the responder answers every request with exactly one completion. The boundary grid is 64 bytes (16 dwords) or 128 bytes (32 dwords), picked by one configuration bit that is captured when the descriptor is taken.

The first request covers the distance from the start address to the next boundary, or less if the transfer is shorter. Every later request is one full boundary long, except the final remainder. The block records the length and the low address bits of each issued request in an in-order table of outstanding requests. Completions are assumed to return in the order of increasing address. Each returning completion header is checked against the oldest table entry, and any disagreement raises a sticky error. A one-cycle done pulse marks the point where the last completion of the transfer has been retired.

Top module: `rcb_read_splitter`

## Requirements
- R1: `desc_ready` is high exactly when no transfer is in progress. A descriptor is taken on a cycle with `desc_valid` and `desc_ready` both high, and `rcb_sel` is captured on that same edge (0 = 16-dword grid, 1 = 32-dword grid).
- R2: The length of a request equals the smaller of the remaining dwords and (grid dwords − (dword address mod grid dwords)), where the dword address is byte address bits above bit 1. No request spans a grid line, and no request has length zero.
- R3: While `req_valid` is high and `req_ready` is low, the request address and length hold steady. On a cycle with both high, the byte address advances by 4 × length and the remaining count drops by length, both on that same edge.
- R4: At most DEPTH requests are outstanding at once. `req_valid` stays low while DEPTH are outstanding.
- R5: Each completion is compared with the oldest outstanding request: its length must match, and its lower address must equal bits 6:0 of that request's byte address. A mismatch, or a completion that arrives with nothing outstanding, sets `err`, which stays high until reset.
- R6: `done` is high for one cycle, in the cycle after the completion that retires the last outstanding request once all requests of the transfer have been issued. From that cycle on, `desc_ready` is high.
- R7: A descriptor of length zero is taken, issues no request, and raises `done` in the next cycle.
- R8: A synchronous active-high reset clears the transfer, the outstanding table, `done` and `err`. Completions seen afterwards are compared only with requests issued after the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle, descriptor can be taken |
| desc_addr | input | ADDR_W | Byte start address of the transfer |
| desc_len | input | LEN_W | Transfer length in dwords |
| rcb_sel | input | 1 | Boundary grid select: 0 = 64 bytes, 1 = 128 bytes |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Downstream takes the request |
| req_addr | output | ADDR_W | Byte address of the request |
| req_len | output | 6 | Request length in dwords (1 to 32) |
| cpl_valid | input | 1 | Completion header present |
| cpl_len | input | 6 | Completion length in dwords |
| cpl_lower_addr | input | 7 | Completion lower address, byte address bits 6:0 |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Sticky completion mismatch flag |

## Verification
The case that is hardest to reach is a full outstanding table. When it is full, issue must stall even though the downstream is ready, and then resume as completions drain the table while requests keep going out in the same cycles. The stimulus withholds all completions during a long unaligned transfer with stuttering `req_ready` until the table is full, then releases them at a slow rate. This makes pops and new requests interleave and overlap. A behavioural model is compared with the design every cycle. A corrupted completion length, a completion with nothing outstanding, and a reset in the middle of a transfer with requests still open check that the error is sticky and that the table is cleared.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

    // Lower-address field width carried by completion headers
    localparam int LA_W    = 7;
    // Widest request in dwords is one 128-byte block
    localparam int CHUNK_W = 6;

    typedef enum logic {
        RCB_64B  = 1'b0,
        RCB_128B = 1'b1
    } rcb_size_e;

    // One entry of the outstanding-request table
    typedef struct packed {
        logic [CHUNK_W-1:0] len;
        logic [LA_W-1:0]    lo_addr;
    } expect_t;

    // Dwords from a dword offset to the end of its boundary block
    function automatic logic [CHUNK_W-1:0] block_room(input logic [4:0] dw_lo,
                                                      input rcb_size_e  sz);
        logic [CHUNK_W-1:0] room;
        if (sz == RCB_128B) begin
            room = 6'd32 - {1'b0, dw_lo};
        end else begin
            room = 6'd16 - {2'b00, dw_lo[3:0]};
        end
        return room;
    endfunction

endpackage

// File: rtl/rcb_chunker.sv
module rcb_chunker
    import rcb_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [4:0]         dw_lo,
    input  logic [LEN_W-1:0]   remaining,
    input  rcb_size_e          size,
    output logic [CHUNK_W-1:0] chunk
);

    logic [CHUNK_W-1:0] room;

    always_comb begin
        room = block_room(dw_lo, size);
        if (remaining < LEN_W'(room)) begin
            chunk = CHUNK_W'(remaining);
        end else begin
            chunk = room;
        end
    end

endmodule

// File: rtl/rcb_expect_fifo.sv
module rcb_expect_fifo
    import rcb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    push,
    input  expect_t din,
    input  logic    pop,
    output expect_t head,
    output logic    empty,
    output logic    full,
    output logic    last
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    expect_t          mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign last  = (count == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + 1'b1;
            end else if (pop && !push) begin
                count <= count - 1'b1;
            end
        end
    end

endmodule

// File: rtl/rcb_cpl_compare.sv
module rcb_cpl_compare
    import rcb_pkg::*;
(
    input  logic               cpl_valid,
    input  logic [CHUNK_W-1:0] cpl_len,
    input  logic [LA_W-1:0]    cpl_lower_addr,
    input  expect_t            head,
    input  logic               empty,
    output logic               pop,
    output logic               bad
);

    logic field_diff;

    always_comb begin
        field_diff = (cpl_len != head.len) || (cpl_lower_addr != head.lo_addr);
        pop        = cpl_valid && !empty;
        bad        = cpl_valid && (empty || field_diff);
    end

endmodule

// File: rtl/rcb_read_splitter.sv
module rcb_read_splitter
    import rcb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int DEPTH  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [ADDR_W-1:0]  desc_addr,
    input  logic [LEN_W-1:0]   desc_len,
    input  logic               rcb_sel,
    output logic               req_valid,
    input  logic               req_ready,
    output logic [ADDR_W-1:0]  req_addr,
    output logic [CHUNK_W-1:0] req_len,
    input  logic               cpl_valid,
    input  logic [CHUNK_W-1:0] cpl_len,
    input  logic [LA_W-1:0]    cpl_lower_addr,
    output logic               done,
    output logic               err
);

    logic               active_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [LEN_W-1:0]   rem_q;
    rcb_size_e          sz_q;
    logic               done_q;
    logic               err_q;

    logic [CHUNK_W-1:0] chunk_len;
    expect_t            push_ent;
    expect_t            head;
    logic               tbl_empty;
    logic               tbl_full;
    logic               tbl_last;
    logic               pop;
    logic               bad;
    logic               fire;
    logic               accept;
    logic               finish;

    rcb_chunker #(.LEN_W(LEN_W)) u_chunk (
        .dw_lo     (addr_q[6:2]),
        .remaining (rem_q),
        .size      (sz_q),
        .chunk     (chunk_len)
    );

    rcb_expect_fifo #(.DEPTH(DEPTH)) u_table (
        .clk   (clk),
        .rst   (rst),
        .push  (fire),
        .din   (push_ent),
        .pop   (pop),
        .head  (head),
        .empty (tbl_empty),
        .full  (tbl_full),
        .last  (tbl_last)
    );

    rcb_cpl_compare u_cmp (
        .cpl_valid      (cpl_valid),
        .cpl_len        (cpl_len),
        .cpl_lower_addr (cpl_lower_addr),
        .head           (head),
        .empty          (tbl_empty),
        .pop            (pop),
        .bad            (bad)
    );

    always_comb begin
        push_ent.len     = chunk_len;
        push_ent.lo_addr = addr_q[LA_W-1:0];
        desc_ready = !active_q;
        req_valid  = active_q && (rem_q != '0) && !tbl_full;
        req_addr   = addr_q;
        req_len    = chunk_len;
        fire       = req_valid && req_ready;
        accept     = desc_valid && !active_q;
        finish     = active_q && (rem_q == '0) && pop && tbl_last;
        done       = done_q;
        err        = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            addr_q   <= '0;
            rem_q    <= '0;
            sz_q     <= RCB_64B;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= finish || (accept && (desc_len == '0));
            if (bad) begin
                err_q <= 1'b1;
            end
            if (accept) begin
                active_q <= (desc_len != '0);
                addr_q   <= desc_addr;
                rem_q    <= desc_len;
                sz_q     <= rcb_size_e'(rcb_sel);
            end else begin
                if (finish) begin
                    active_q <= 1'b0;
                end
                if (fire) begin
                    addr_q <= addr_q + ADDR_W'({chunk_len, 2'b00});
                    rem_q  <= rem_q - LEN_W'(chunk_len);
                end
            end
        end
    end

endmodule

// File: rtl/rcb_read_splitter_sva.sv
module rcb_read_splitter_sva #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12,
    parameter int DEPTH  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [LEN_W-1:0] desc_len,
    input logic             rcb_sel,
    input logic             req_valid,
    input logic             req_ready,
    input logic [4:0]       req_lo,
    input logic [5:0]       req_len,
    input logic             cpl_valid,
    input logic             done,
    input logic             err
);

    localparam int OC_W = $clog2(DEPTH + 1) + 1;

    logic            grid_sel;
    logic [OC_W-1:0] out_cnt;
    logic [6:0]      span_end;
    logic [6:0]      grid_dw;

    always_ff @(posedge clk) begin
        if (rst) begin
            grid_sel <= 1'b0;
            out_cnt  <= '0;
        end else begin
            if (desc_valid && desc_ready) begin
                grid_sel <= rcb_sel;
            end
            out_cnt <= out_cnt
                     + OC_W'(req_valid && req_ready)
                     - OC_W'(cpl_valid && (out_cnt != '0));
        end
    end

    always_comb begin
        grid_dw  = grid_sel ? 7'd32 : 7'd16;
        span_end = (grid_sel ? {2'b00, req_lo} : {3'b000, req_lo[3:0]})
                 + {1'b0, req_len};
    end

    // R1
    busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !desc_ready);

    // R2
    no_cross_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (span_end <= grid_dw) && (req_len != 6'd0));

    // R3
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> req_valid && $stable(req_lo) && $stable(req_len));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        out_cnt <= OC_W'(DEPTH));

    // R4
    full_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_cnt == OC_W'(DEPTH)) |-> !req_valid);

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> desc_ready && !req_valid);

    // R7
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        (desc_valid && desc_ready && (desc_len == '0)) |=> done && desc_ready);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !done && !err && desc_ready && !req_valid);

endmodule

bind rcb_read_splitter rcb_read_splitter_sva #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .DEPTH  (DEPTH)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_len   (desc_len),
    .rcb_sel    (rcb_sel),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_lo     (req_addr[6:2]),
    .req_len    (req_len),
    .cpl_valid  (cpl_valid),
    .done       (done),
    .err        (err)
);

// File: tb/rcb_read_splitter_tb.sv
module rcb_read_splitter_tb;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int DEPTH  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic              rcb_sel = 1'b0;
    logic              req_valid;
    logic              req_ready = 1'b1;
    logic [ADDR_W-1:0] req_addr;
    logic [5:0]        req_len;
    logic              cpl_valid = 1'b0;
    logic [5:0]        cpl_len = '0;
    logic [6:0]        cpl_lower_addr = '0;
    logic              done;
    logic              err;

    rcb_read_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_addr(desc_addr), .desc_len(desc_len), .rcb_sel(rcb_sel),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len),
        .cpl_valid(cpl_valid), .cpl_len(cpl_len), .cpl_lower_addr(cpl_lower_addr),
        .done(done), .err(err)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    // Reference model state
    bit m_started = 0;
    bit m_active  = 0;
    int m_addr    = 0;
    int m_rem     = 0;
    bit m_rcb     = 0;
    bit m_done    = 0;
    bit m_err     = 0;
    int q_len[$];
    int q_la[$];
    int n_issued  = 0;

    // Responder state
    int rq_len[$];
    int rq_la[$];
    bit cpl_en      = 1;
    int cpl_period  = 1;
    bit ready_stut  = 0;
    bit corrupt_next = 0;
    bit stray_next  = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic int grid(input bit sel);
        return sel ? 32 : 16;
    endfunction

    function automatic int m_len();
        int room;
        room = grid(m_rcb) - ((m_addr / 4) % grid(m_rcb));
        return (m_rem < room) ? m_rem : room;
    endfunction

    function automatic bit m_reqv();
        return m_active && (m_rem > 0) && (q_len.size() < DEPTH);
    endfunction

    // Model step
    always @(posedge clk) begin
        bit act0;
        bit rv;
        int l;
        m_started = 1;
        cyc++;
        if (rst) begin
            m_active = 0; m_addr = 0; m_rem = 0; m_rcb = 0;
            m_done = 0; m_err = 0;
            q_len.delete(); q_la.delete(); rq_len.delete(); rq_la.delete();
        end else begin
            act0 = m_active;
            rv = m_reqv();
            l = m_len();
            m_done = 0;
            if (cpl_valid) begin
                if (q_len.size() == 0) begin
                    m_err = 1;
                end else begin
                    if ((int'(cpl_len) != q_len[0]) || (int'(cpl_lower_addr) != q_la[0])) m_err = 1;
                    void'(q_len.pop_front());
                    void'(q_la.pop_front());
                    if (act0 && (m_rem == 0) && (q_len.size() == 0)) begin
                        m_done = 1;
                        m_active = 0;
                    end
                end
            end
            if (rv && req_ready) begin
                q_len.push_back(l); q_la.push_back(m_addr & 'h7f);
                rq_len.push_back(l); rq_la.push_back(m_addr & 'h7f);
                m_addr = m_addr + 4 * l;
                m_rem  = m_rem - l;
                n_issued++;
            end
            if (!act0 && desc_valid) begin
                if (desc_len == 0) begin
                    m_done = 1;
                end else begin
                    m_active = 1;
                    m_addr = int'(desc_addr);
                    m_rem = int'(desc_len);
                    m_rcb = rcb_sel;
                end
            end
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    // Per-cycle comparison, then responder drive
    always @(negedge clk) begin
        if (m_started) begin
            chk(desc_ready == !m_active, "R1 desc_ready", desc_ready, !m_active);
            chk(req_valid == m_reqv(), "R4 req_valid", req_valid, m_reqv());
            if (req_valid && m_reqv()) begin
                chk(int'(req_len) == m_len(), "R2 req_len", req_len, m_len());
                chk(int'(req_addr) == m_addr, "R3 req_addr", req_addr, m_addr);
            end
            chk(done == m_done, "R6 done", done, m_done);
            chk(err == m_err, "R5 err", err, m_err);
        end
        req_ready = ready_stut ? ((cyc % 3) != 0) : 1'b1;
        cpl_valid = 1'b0;
        if (stray_next) begin
            stray_next = 0;
            cpl_valid = 1'b1; cpl_len = 6'd1; cpl_lower_addr = 7'd0;
        end else if (cpl_en && (rq_len.size() > 0) && ((cyc % cpl_period) == 0)) begin
            cpl_valid = 1'b1;
            cpl_len = 6'(rq_len.pop_front() + (corrupt_next ? 1 : 0));
            cpl_lower_addr = 7'(rq_la.pop_front());
            corrupt_next = 0;
        end
    end

    function automatic int exp_count(input int a, input int n, input bit sel);
        int c = 0;
        while (n > 0) begin
            int room = grid(sel) - ((a / 4) % grid(sel));
            int l = (n < room) ? n : room;
            a += 4 * l; n -= l; c++;
        end
        return c;
    endfunction

    task automatic give_desc(input int a, input int n, input bit sel);
        @(negedge clk);
        desc_valid = 1'b1; desc_addr = ADDR_W'(a); desc_len = LEN_W'(n); rcb_sel = sel;
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
    endtask

    task automatic run_xfer(input int a, input int n, input bit sel, input string tag);
        bit seen;
        n_issued = 0;
        give_desc(a, n, sel);
        wait_done(seen);
        chk(seen, {tag, " R6 done seen"}, seen, 1);
        chk(n_issued == exp_count(a, n, sel), {tag, " R2 request count"}, n_issued, exp_count(a, n, sel));
        @(negedge clk);
        chk(desc_ready == 1'b1, {tag, " R6 idle after done"}, desc_ready, 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        cpl_en = 0; corrupt_next = 0; stray_next = 0;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cpl_en = 1; cpl_period = 1; ready_stut = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(desc_ready && !req_valid && !done && !err, "R8 reset state",
            {desc_ready, req_valid, done, err}, 4'b1000);

        // R2 aligned, 64-byte grid: 16,16,8
        run_xfer('h1000, 40, 1'b0, "aligned64");
        // R2 unaligned, 64-byte grid: 3,16,16,15
        run_xfer('h1034, 50, 1'b0, "unaligned64");
        // R1 rcb_sel=1 captured: 28,32,10
        run_xfer('h2010, 70, 1'b1, "unaligned128");
        // R2 short inside one block
        run_xfer('h3008, 5, 1'b1, "short128");

        // R7 zero length
        n_issued = 0;
        give_desc('h3100, 0, 1'b0);
        chk(done == 1'b1, "R7 zero-length done", done, 1);
        chk(req_valid == 1'b0, "R7 zero-length no request", req_valid, 0);
        repeat (3) @(negedge clk);
        chk(n_issued == 0, "R7 zero-length count", n_issued, 0);

        // R3 stuttering ready with slow completions
        ready_stut = 1; cpl_period = 3;
        run_xfer('h2044, 90, 1'b1, "stutter128");

        // R4 table fill: hold completions off
        cpl_en = 0; cpl_period = 2;
        n_issued = 0;
        give_desc('h5004, 200, 1'b0);
        repeat (30) @(negedge clk);
        chk(req_valid == 1'b0, "R4 stall when full", req_valid, 0);
        chk(rq_len.size() == DEPTH, "R4 outstanding count", rq_len.size(), DEPTH);
        cpl_en = 1;
        begin
            bit seen;
            wait_done(seen);
            chk(seen, "R4 drain done", seen, 1);
        end
        chk(n_issued == exp_count('h5004, 200, 1'b0), "R4 request count", n_issued,
            exp_count('h5004, 200, 1'b0));
        ready_stut = 0; cpl_period = 1;

        // R5 corrupted completion length
        corrupt_next = 1;
        run_xfer('h4000, 20, 1'b0, "corrupt");
        chk(err == 1'b1, "R5 mismatch sets err", err, 1);
        repeat (4) @(negedge clk);
        chk(err == 1'b1, "R5 err sticky", err, 1);
        do_reset();
        chk(err == 1'b0, "R8 reset clears err", err, 0);

        // R5 stray completion while idle
        @(negedge clk);
        stray_next = 1;
        repeat (2) @(negedge clk);
        chk(err == 1'b1, "R5 stray completion", err, 1);
        do_reset();

        // R8 reset in mid-transfer with requests outstanding
        cpl_en = 0;
        give_desc('h6000, 100, 1'b1);
        repeat (8) @(negedge clk);
        do_reset();
        chk(desc_ready && !req_valid && !err, "R8 mid-transfer reset",
            {desc_ready, req_valid, err}, 3'b100);
        run_xfer('h7020, 45, 1'b0, "after_reset");
        chk(err == 1'b0, "R8 stale entries cleared", err, 0);

        repeat (5) @(negedge clk);
        report();
        $finish;
    end

endmodule